// File: doc/BRIEF.md
# Low-Power SDR SDRAM Power-Up Sequencer

This block takes a 16-bit, four-bank low-power single-data-rate SDRAM from power-up to a usable state. It starts after reset is released, holds the command bus at NOP for a fixed settling pause, and then issues a fixed command stream. The stream is precharge-all, a run of auto-refresh commands, a load of the standard mode register, and a load of the extended mode register that selects which part of the array self-refresh keeps. The block then raises `ready`, and the memory controller may start issuing row activations.

Every gap between commands is a parameter in clock cycles. These are the settling pause, the precharge recovery, the refresh cycle time and the register-load recovery. Each is derived from the clock frequency when the block is integrated. The CAS latency, burst length code, burst ordering and partial-array selection come in as static configuration inputs. They are read when the matching register load is issued. All command-bus outputs come from flops.

Top module: `lpsdr_init_seq`

## Requirements
- R1: While reset is asserted, the bus shows NOP, which is `cs_n`=0 with `ras_n`, `cas_n` and `we_n` all 1. During reset `ba` and `addr` are zero and `ready` is 0.
- R2: After reset is released, the bus shows NOP for exactly `PAUSE_CYC` sampled cycles. The first command after that is precharge-all, which is `cs_n`, `ras_n` and `we_n` at 0, `cas_n` at 1, `addr[10]`=1, all other address bits 0 and `ba`=00.
- R3: `N_REF` auto-refresh commands follow (`N_REF` ≥ 2). Auto-refresh is `cs_n`, `ras_n` and `cas_n` at 0 with `we_n` at 1, and `ba` and `addr` at zero. The first comes exactly `T_RP` cycles after precharge-all, and each later one comes exactly `T_RFC` cycles after the one before.
- R4: Exactly `T_RFC` cycles after the last refresh, a standard register load is issued. It has all four control pins at 0 and `ba`=00. In `addr`, bits [2:0] hold the burst length code and bit 3 holds the burst ordering (1 = interleaved). Bits [6:4] hold the CAS latency: 3'd3 when `cas_lat3`=1 and 3'd2 otherwise. All higher bits are 0.
- R5: Burst length codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats and are sent unchanged. Code 7 selects a full page. The reserved codes 4, 5 and 6 are sent as 7.
- R6: Exactly `T_MRD` cycles after the standard load, an extended register load is issued. It has all four control pins at 0 and `ba`=10, with `addr[2:0]` equal to `pasr_sel` and every other address bit 0.
- R7: `ready` stays 0 until exactly `T_MRD` cycles after the extended load. It then goes to 1 and stays there until the next reset, and the bus shows NOP from that cycle on.
- R8: Every cycle that does not carry one of the commands above shows NOP with `ba` and `addr` at zero. No activate, read or write encoding ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| burst_len | input | 3 | Burst length code (0..3 = 1/2/4/8 beats, 7 = full page) |
| burst_il | input | 1 | Burst ordering, 1 = interleaved |
| pasr_sel | input | 3 | Partial-array self-refresh selection |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete |

## Verification
The bench sweeps every combination of CAS latency, burst length code, burst ordering and partial-array selection, which is 256 runs, and resets the block before each one. Each run compares every bus cycle against a timeline computed from the gap parameters. That comparison separates a wrong gap, a missing or extra refresh, and a command that leaks into a NOP cycle. The sweep over burst codes separates the pass-through codes from the reserved codes that are folded to full page. The sweeps over latency, ordering and array selection show whether each field lands in its own address bits and in the correct register load.

// File: rtl/lpsdr_init_seq.sv
`timescale 1ns/1ps
module lpsdr_init_seq #(
  parameter int PAUSE_CYC = 50000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 18,
  parameter int T_MRD     = 2,
  parameter int N_REF     = 2,
  parameter int ADDR_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic [2:0]        burst_len,
  input  logic              burst_il,
  input  logic [2:0]        pasr_sel,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int CW = $clog2(PAUSE_CYC + T_RP + T_RFC + T_MRD + 2);
  localparam int RW = $clog2(N_REF + 1);

  typedef enum logic [2:0] {S_PAUSE, S_PREA, S_REF, S_MRS, S_EMRS, S_WAIT, S_DONE} st_t;

  st_t           st, nxt_st, after;
  logic [CW-1:0] cnt;
  logic [RW-1:0] nref;
  logic [3:0]    cmd_c;
  logic [1:0]    ba_c;
  logic [ADDR_W-1:0] addr_c;
  int            gap;
  logic [2:0]    bl_code;

  assign bl_code = burst_len[2] ? 3'b111 : burst_len;

  always_comb begin
    cmd_c  = 4'b0111;
    ba_c   = 2'b00;
    addr_c = '0;
    gap    = 0;
    after  = S_DONE;
    case (st)
      S_PREA: begin
        cmd_c      = 4'b0010;
        addr_c[10] = 1'b1;
        gap        = T_RP;
        after      = S_REF;
      end
      S_REF: begin
        cmd_c = 4'b0001;
        gap   = T_RFC;
        after = (nref == RW'(N_REF - 1)) ? S_MRS : S_REF;
      end
      S_MRS: begin
        cmd_c       = 4'b0000;
        addr_c[6:0] = {1'b0, cas_lat3 ? 2'b11 : 2'b10, burst_il, bl_code};
        gap         = T_MRD;
        after       = S_EMRS;
      end
      S_EMRS: begin
        cmd_c       = 4'b0000;
        ba_c        = 2'b10;
        addr_c[2:0] = pasr_sel;
        gap         = T_MRD;
        after       = S_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st                     <= S_PAUSE;
      nxt_st                 <= S_PAUSE;
      cnt                    <= CW'(PAUSE_CYC - 1);
      nref                   <= '0;
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba                     <= 2'b00;
      addr                   <= '0;
      ready                  <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_c;
      ba    <= ba_c;
      addr  <= addr_c;
      ready <= (st == S_DONE);
      case (st)
        S_PAUSE, S_WAIT: begin
          if (cnt == '0) st <= (st == S_PAUSE) ? S_PREA : nxt_st;
          else           cnt <= cnt - 1'b1;
        end
        S_DONE: ;
        default: begin
          if (st == S_REF) nref <= nref + 1'b1;
          if (gap <= 1) begin
            st <= after;
          end else begin
            st     <= S_WAIT;
            cnt    <= CW'(gap - 2);
            nxt_st <= after;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lpsdr_init_seq_chk.sv
`timescale 1ns/1ps
module lpsdr_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);
  wire is_load = !cs_n && !ras_n && !cas_n && !we_n;
  wire is_prea = !cs_n && !ras_n && cas_n && !we_n;

  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  a_r8_no_activate: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !(!ras_n && cas_n && we_n));

  a_r8_no_column: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !(ras_n && !cas_n));

  a_r2_prea_a10: assert property (@(posedge clk) disable iff (!rst_n)
    is_prea |-> (addr[10] && ba == 2'b00));

  a_r4_load_bank: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (ba == 2'b00 || ba == 2'b10));

  a_r6_emrs_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && ba == 2'b10) |-> (addr[ADDR_W-1:3] == '0));
endmodule

bind lpsdr_init_seq lpsdr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lpsdr_init_seq_tb.sv
`timescale 1ns/1ps
module lpsdr_init_seq_tb;
  localparam int P    = 20;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TMRD = 2;
  localparam int NR   = 3;
  localparam int AW   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cas_lat3 = 1'b0;
  logic [2:0] burst_len = 3'd0;
  logic burst_il = 1'b0;
  logic [2:0] pasr_sel = 3'd0;
  logic cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lpsdr_init_seq #(.PAUSE_CYC(P), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
                   .N_REF(NR), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .burst_len(burst_len),
    .burst_il(burst_il), .pasr_sel(pasr_sel), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cfg(input bit cl, input logic [2:0] bl, input bit bt,
                         input logic [2:0] pa);
    int t_prea, t_mrs, t_emrs, t_rdy;
    logic [2:0] blx;
    @(negedge clk);
    rst_n = 1'b0;
    cas_lat3 = cl; burst_len = bl; burst_il = bt; pasr_sel = pa;
    @(negedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n, ba, addr, ready} == {4'b0111, 2'b00, 13'd0, 1'b0},
        "R1 reset state", {cs_n, ras_n, cas_n, we_n, ready}, 32'h0e);
    rst_n = 1'b1;
    blx    = bl[2] ? 3'd7 : bl;
    t_prea = P + 1;
    t_mrs  = t_prea + TRP + (NR - 1) * TRFC + TRFC;
    t_emrs = t_mrs + TMRD;
    t_rdy  = t_emrs + TMRD;
    for (int k = 1; k <= t_rdy + 4; k++) begin
      logic [3:0] ecmd;
      logic [1:0] eba;
      logic [AW-1:0] eaddr;
      string tag;
      @(negedge clk);
      ecmd = 4'b0111; eba = 2'b00; eaddr = '0;
      tag = (k < t_prea) ? "R2 pause NOP" : (k >= t_rdy) ? "R7 quiet after ready" : "R8 idle NOP";
      if (k == t_prea) begin
        ecmd = 4'b0010; eaddr[10] = 1'b1; tag = "R2 precharge-all";
      end
      for (int i = 0; i < NR; i++)
        if (k == t_prea + TRP + i * TRFC) begin
          ecmd = 4'b0001; tag = "R3 auto-refresh";
        end
      if (k == t_mrs) begin
        ecmd = 4'b0000;
        eaddr[6:0] = {1'b0, cl ? 2'b11 : 2'b10, bt, blx};
        tag = (bl[2] && bl != 3'd7) ? "R5 reserved burst code" : "R4 mode load";
      end
      if (k == t_emrs) begin
        ecmd = 4'b0000; eba = 2'b10; eaddr[2:0] = pa; tag = "R6 extended load";
      end
      chk({cs_n, ras_n, cas_n, we_n} == ecmd, tag, {cs_n, ras_n, cas_n, we_n}, ecmd);
      chk(ba == eba && addr == eaddr, tag, {ba, addr}, {eba, eaddr});
      chk(ready == (k >= t_rdy), "R7 ready timing", ready, (k >= t_rdy));
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 8; b++)
        for (int o = 0; o < 2; o++)
          for (int a = 0; a < 8; a++)
            run_cfg(c[0], b[2:0], o[0], a[2:0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule